// File: doc/BRIEF.md
# Nibble-Lookup Byte Class Detector

This block classifies every byte of a wide input vector in parallel against a small programmable table. Each lane takes the low four bits of its byte as an index into a 16-entry byte table, fetches that entry (or a zero byte when the lane's top bit is set), and then compares the fetched byte with the lane's own input byte. Equality marks the byte as a member of the character class held in the table. Because each table slot can hold only one character, a single table can describe any class whose members all have distinct low nibbles. ASCII whitespace (space, tab, line feed, carriage return) is one such class.

To program the table, software writes one slot at a time through a simple index/data write port. Vectors then stream in with a valid flag, one per clock if needed. One clock later the block presents a per-lane match mask together with the raw looked-up vector, so other logic can reuse the shuffle result. Slots that belong to no class member should hold a filler byte whose low nibble differs from the slot index, so that no input can ever equal it.

Top module: `nibclass_top`

## Requirements
- R1: While reset is asserted and after its release, before any valid vector, out_valid, out_mask and out_shuf are all zero. Reset loads table entry i with the filler value 0xF0 | (15 - i), so no input byte matches until the table is rewritten.
- R2: For a lane whose byte has bit 7 clear, the looked-up byte is the table entry indexed by bits 3:0 of that byte.
- R3: For a lane whose byte has bit 7 set, the looked-up byte is 0x00, whatever the table holds.
- R4: A lane's mask bit is 1 exactly when its looked-up byte equals its input byte. A byte with bit 7 set never matches, including input 0x80 against an entry of 0x00.
- R5: A write (wr_en high, 4-bit wr_idx, 8-bit wr_data) at a clock edge is used by vectors presented in the following cycle. A vector presented in the same cycle as the write still sees the previous entry.
- R6: A vector accepted with in_valid at a clock edge appears on out_mask/out_shuf with out_valid high right after that edge. After an edge without in_valid, out_valid is low and out_mask/out_shuf keep their last values.
- R7: Lane i is input bits 8i+7:8i, out_shuf bits 8i+7:8i and out_mask bit i. Byte 0 is in the least significant bits.
- R8: With entries 0, 9, 10 and 13 holding 0x20, 0x09, 0x0A and 0x0D, and all other entries holding filler, the mask flags exactly the bytes space, tab, line feed and carriage return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 4 | Table slot to write |
| wr_data | input | 8 | Byte written to the slot |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_vec | input | 128 | Sixteen input bytes, byte 0 in bits 7:0 |
| out_valid | output | 1 | Registered result is valid |
| out_mask | output | 16 | Per-lane class match, bit i for byte i |
| out_shuf | output | 128 | Per-lane looked-up byte |

## Verification
The bench builds the block with its default parameters: 16 lanes, 8-bit bytes, a 4-bit index, and the zero-on-top-bit variant. Because the index is only four bits wide, the vector stream can be rotated so that all 256 byte values pass through every lane under each table loaded. This covers the whitespace table, the reset filler table and two arithmetic pseudo-random tables. The bench places a write and a vector in the same cycle to reach the write-ordering corner. It puts 0x00 in a slot to show that a top-bit input cannot alias a zero entry.

// File: rtl/nibclass_pkg.sv
package nibclass_pkg;

   // How a lane treats a byte whose most significant bit is set.
   typedef enum logic {
      MSB_PASS = 1'b0,   // index with low bits regardless of the top bit
      MSB_ZERO = 1'b1    // top bit set forces the looked-up byte to zero
   } msb_mode_e;

endpackage : nibclass_pkg

// File: rtl/nibclass_table.sv
module nibclass_table #(
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 4,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [BYTE_W-1:0]         wr_data,
   output logic [DEPTH*BYTE_W-1:0]   tbl_flat
);

   logic [BYTE_W-1:0] mem [DEPTH];

   // Reset value: upper bits all ones, low nibble the complement of the slot
   // index, so the filler never carries its own slot's low nibble.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= {{(BYTE_W-IDX_W){1'b1}}, ~IDX_W'(i)};
         end
      end else if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_flat
         assign tbl_flat[g*BYTE_W +: BYTE_W] = mem[g];
      end
   endgenerate

   // R5: a written slot holds the written byte on the next cycle.
   assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (tbl_flat[int'($past(wr_idx))*BYTE_W +: BYTE_W] == $past(wr_data)));

endmodule : nibclass_table

// File: rtl/nibclass_lane.sv
module nibclass_lane
   import nibclass_pkg::*;
#(
   parameter int        BYTE_W   = 8,
   parameter int        IDX_W    = 4,
   parameter msb_mode_e MSB_MODE = MSB_ZERO,
   localparam int       DEPTH    = 1 << IDX_W
) (
   input  logic [BYTE_W-1:0]        byte_in,
   input  logic [DEPTH*BYTE_W-1:0]  tbl_flat,
   output logic [BYTE_W-1:0]        shuf_out,
   output logic                     hit
);

   logic [IDX_W-1:0]  idx;
   logic [BYTE_W-1:0] entry;

   assign idx   = byte_in[IDX_W-1:0];
   assign entry = tbl_flat[int'(idx)*BYTE_W +: BYTE_W];

   generate
      if (MSB_MODE == MSB_ZERO) begin : g_zero
         assign shuf_out = byte_in[BYTE_W-1] ? '0 : entry;
      end else begin : g_pass
         assign shuf_out = entry;
      end
   endgenerate

   assign hit = (shuf_out == byte_in);

endmodule : nibclass_lane

// File: rtl/nibclass_stage.sv
module nibclass_stage #(
   parameter int LANES  = 16,
   parameter int BYTE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     d_valid,
   input  logic [LANES-1:0]         d_mask,
   input  logic [LANES*BYTE_W-1:0]  d_shuf,
   output logic                     q_valid,
   output logic [LANES-1:0]         q_mask,
   output logic [LANES*BYTE_W-1:0]  q_shuf
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_mask  <= '0;
         q_shuf  <= '0;
      end else begin
         q_valid <= d_valid;
         if (d_valid) begin
            q_mask <= d_mask;
            q_shuf <= d_shuf;
         end
      end
   end

   // R6: result flags follow accepted vectors by one clock.
   assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |=> q_valid);
   assert_idle_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !d_valid |=> !q_valid);
   assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !d_valid |=> ($stable(q_mask) && $stable(q_shuf)));

endmodule : nibclass_stage

// File: rtl/nibclass_top.sv
module nibclass_top
   import nibclass_pkg::*;
#(
   parameter int        LANES    = 16,
   parameter int        BYTE_W   = 8,
   parameter int        IDX_W    = 4,
   parameter msb_mode_e MSB_MODE = MSB_ZERO,
   localparam int       DEPTH    = 1 << IDX_W,
   localparam int       VEC_W    = LANES * BYTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [BYTE_W-1:0]  wr_data,
   input  logic               in_valid,
   input  logic [VEC_W-1:0]   in_vec,
   output logic               out_valid,
   output logic [LANES-1:0]   out_mask,
   output logic [VEC_W-1:0]   out_shuf
);

   generate
      if (LANES < 1) begin : g_chk_lanes
         $error("nibclass_top: LANES must be at least 1");
      end
      if (IDX_W < 1 || IDX_W >= BYTE_W) begin : g_chk_idx
         $error("nibclass_top: IDX_W must lie between 1 and BYTE_W-1");
      end
      if (IDX_W > 8) begin : g_chk_depth
         $error("nibclass_top: table deeper than 256 entries not supported");
      end
   endgenerate

   logic [DEPTH*BYTE_W-1:0] tbl_flat;
   logic [LANES-1:0]        lane_hit;
   logic [VEC_W-1:0]        lane_shuf;

   nibclass_table #(
      .BYTE_W (BYTE_W),
      .IDX_W  (IDX_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .tbl_flat (tbl_flat)
   );

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_lane
         nibclass_lane #(
            .BYTE_W   (BYTE_W),
            .IDX_W    (IDX_W),
            .MSB_MODE (MSB_MODE)
         ) u_lane (
            .byte_in  (in_vec[l*BYTE_W +: BYTE_W]),
            .tbl_flat (tbl_flat),
            .shuf_out (lane_shuf[l*BYTE_W +: BYTE_W]),
            .hit      (lane_hit[l])
         );

         // R4: a registered match implies an equal byte with a clear top bit.
         if (MSB_MODE == MSB_ZERO) begin : g_msb_chk
            assert_match_clear_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
               (out_valid && out_mask[l]) |-> !out_shuf[l*BYTE_W + BYTE_W-1]);
            // R3: a top-bit byte produces a zero looked-up byte one clock later.
            assert_msb_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
               (in_valid && in_vec[l*BYTE_W + BYTE_W-1]) |=>
                  (out_shuf[l*BYTE_W +: BYTE_W] == '0 && !out_mask[l]));
         end
      end
   endgenerate

   nibclass_stage #(
      .LANES  (LANES),
      .BYTE_W (BYTE_W)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (in_valid),
      .d_mask  (lane_hit),
      .d_shuf  (lane_shuf),
      .q_valid (out_valid),
      .q_mask  (out_mask),
      .q_shuf  (out_shuf)
   );

endmodule : nibclass_top

// File: tb/sim_nibclass_top.sv
`timescale 1ns/1ps
module sim_nibclass_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [3:0]   wr_idx = '0;
   logic [7:0]   wr_data = '0;
   logic         in_valid = 1'b0;
   logic [127:0] in_vec = '0;
   logic         out_valid;
   logic [15:0]  out_mask;
   logic [127:0] out_shuf;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [7:0] mtab [16];

   always #2 clk = ~clk;

   nibclass_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .in_valid(in_valid), .in_vec(in_vec), .out_valid(out_valid),
      .out_mask(out_mask), .out_shuf(out_shuf)
   );

   function automatic logic [127:0] exp_shuf(input logic [127:0] v);
      logic [127:0] r;
      for (int i = 0; i < 16; i++) begin
         logic [7:0] b;
         b = v[i*8 +: 8];
         r[i*8 +: 8] = b[7] ? 8'h00 : mtab[b % 16];
      end
      return r;
   endfunction

   function automatic logic [15:0] exp_mask(input logic [127:0] v);
      logic [127:0] s;
      logic [15:0]  m;
      s = exp_shuf(v);
      for (int i = 0; i < 16; i++) m[i] = (s[i*8 +: 8] == v[i*8 +: 8]);
      return m;
   endfunction

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      mtab[idx] = d;
   endtask

   // send a vector, then check the registered result one clock later
   task automatic send_chk(input string tag, input logic [127:0] v);
      @(negedge clk);
      in_valid = 1'b1; in_vec = v;
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " valid"}, {127'd0, out_valid}, 128'd1);
      chk({tag, " shuf"}, out_shuf, exp_shuf(v));
      chk({tag, " mask"}, {112'd0, out_mask}, {112'd0, exp_mask(v)});
   endtask

   // every byte value through every lane
   task automatic sweep(input string tag);
      for (int b = 0; b < 256; b++) begin
         logic [127:0] v;
         for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'((b + 17*i) % 256);
         send_chk(tag, v);
      end
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mtab[i] = 8'hF0 | 8'(15 - i);
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 reset outputs", {out_shuf[126:0], out_valid}, 128'd0);
      chk("R1 reset mask", {112'd0, out_mask}, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {out_shuf[126:0], out_valid}, 128'd0);
      // R1 filler table: nothing matches, R2 R3 R4 R7 lookup behaviour
      sweep("R1 R2 R3 filler sweep");

      // R8 whitespace configuration
      wr(0, 8'h20); wr(9, 8'h09); wr(10, 8'h0A); wr(13, 8'h0D);
      sweep("R8 R4 whitespace sweep");
      begin
         logic [127:0] v;
         v = '0;
         v[7:0] = 8'h20; v[15:8] = 8'h41; v[23:16] = 8'h09; v[31:24] = 8'hA0;
         v[39:32] = 8'h0A; v[47:40] = 8'h8D; v[55:48] = 8'h0D; v[63:56] = 8'h30;
         send_chk("R8 text", v);
         chk("R8 mask literal", {112'd0, out_mask}, {112'd0, 16'b0000_0000_0101_0101});
      end

      // R7 lane order: space only in lane 5
      begin
         logic [127:0] v;
         v = {16{8'h41}};
         v[5*8 +: 8] = 8'h20;
         send_chk("R7 single lane", v);
         chk("R7 mask bit", {112'd0, out_mask}, {112'd0, 16'h0020});
      end

      // R4: zero entry vs 0x80 and 0x00
      wr(0, 8'h00);
      begin
         logic [127:0] v;
         v = {16{8'h80}};
         v[7:0] = 8'h00;
         send_chk("R4 zero entry", v);
         chk("R4 only lane0", {112'd0, out_mask}, {112'd0, 16'h0001});
      end

      // R5: write and vector in the same cycle
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd3; wr_data = 8'h03;
      in_valid = 1'b1; in_vec = {16{8'h03}};
      @(negedge clk);
      wr_en = 1'b0; in_valid = 1'b0;
      chk("R5 same cycle old entry", {112'd0, out_mask}, 128'd0);
      mtab[3] = 8'h03;
      send_chk("R5 next cycle new entry", {16{8'h03}});
      chk("R5 all lanes hit", {112'd0, out_mask}, {112'd0, 16'hFFFF});

      // R6: idle cycles keep data, drop valid
      @(negedge clk);
      chk("R6 valid low", {127'd0, out_valid}, 128'd0);
      chk("R6 mask held", {112'd0, out_mask}, {112'd0, 16'hFFFF});
      chk("R6 shuf held", out_shuf, {16{8'h03}});
      // R6 back-to-back vectors
      @(negedge clk);
      in_valid = 1'b1; in_vec = {16{8'h03}};
      @(negedge clk);
      in_vec = {16{8'h04}};
      chk("R6 b2b first", {112'd0, out_mask}, {112'd0, 16'hFFFF});
      @(negedge clk);
      in_valid = 1'b0;
      chk("R6 b2b second", out_shuf, exp_shuf({16{8'h04}}));
      chk("R6 b2b valid", {127'd0, out_valid}, 128'd1);

      // R2 pseudo-random tables
      for (int t = 0; t < 2; t++) begin
         for (int i = 0; i < 16; i++) wr(i, 8'((i * 37 + t * 91 + 5) % 256));
         wr(7 + t, 8'h07 + 8'(t)); // ensure some hits
         sweep("R2 R4 random table sweep");
      end

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog R6 act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule : sim_nibclass_top